// File: doc/BRIEF.md
# Streaming Connected Component Labeler

This block labels the foreground pixels of a binary raster that arrives one pixel at a time, in row-major order, in a single pass. Each foreground pixel gets a label code drawn from the labels of the four neighbours that have already been processed: the left pixel in the current row, and the upper-left, upper and upper-right pixels in the row above. Together these give 8-connectivity. The block keeps only one row of labels in a delay line, so it never holds a whole image.

When the two sides of the current pixel carry different labels, the block emits an ordered merge pair. One side is the label reached through the left, upper-left and upper neighbours; the other is the upper-right neighbour. A downstream equivalence table uses these pairs to join the two labels. Resolving those equivalences and accumulating features are left to other blocks.

The pixel stream has a valid strobe, a start-of-frame marker on the first pixel and an end-of-line marker on the last pixel of each row. Every row holds exactly `IMG_W` pixels. Idle cycles may be placed anywhere between pixels.

Top module: `ccl_stream_labeler`

## Requirements
- R1: A background pixel (`pix_fg`=0) is given label 0 and never produces a merge pair.
- R2: A foreground pixel with no labelled neighbour gets a fresh label. Fresh labels start at 1 on the start-of-frame pixel and rise by one with each new label.
- R3: A foreground pixel with at least one labelled neighbour takes the smallest nonzero label among its left, upper-left, upper and upper-right neighbours.
- R4: Let G be the smallest nonzero label among the left, upper-left and upper neighbours, and U the upper-right label. When G and U are both nonzero and differ, `mrg_vld` is raised together with the pixel's label, with `mrg_a` = min(G,U) and `mrg_b` = max(G,U). In that case the pixel's label equals `mrg_a`.
- R5: Out-of-image neighbours count as background. On the start-of-frame row there are no upper neighbours. On the first pixel of a row (after `pix_eol` or at `pix_sof`) there are no left or upper-left neighbours. On the pixel that carries `pix_eol` there is no upper-right neighbour.
- R6: Outputs are registered. `lbl_vld` is high exactly one cycle after each accepted pixel. Idle cycles raise neither `lbl_vld` nor `mrg_vld`, and leave the labels of later pixels unchanged.
- R7: Once labels 1 to 2^LBL_W-1 have all been issued, each further fresh-label request returns the all-ones label and sets `lbl_ovf`. The flag stays high until a start-of-frame pixel that issues no label beyond the exhausted range.
- R8: After synchronous reset, `lbl_vld`, `mrg_vld`, `lbl_out`, `mrg_a`, `mrg_b` and `lbl_ovf` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_vld | input | 1 | Pixel present this cycle |
| pix_fg | input | 1 | Pixel is foreground |
| pix_sof | input | 1 | First pixel of a frame |
| pix_eol | input | 1 | Last pixel of a row |
| lbl_vld | output | 1 | Label output valid |
| lbl_out | output | LBL_W | Label of the pixel accepted one cycle earlier |
| mrg_vld | output | 1 | Merge pair valid |
| mrg_a | output | LBL_W | Smaller label of the merge pair |
| mrg_b | output | LBL_W | Larger label of the merge pair |
| lbl_ovf | output | 1 | Fresh labels exhausted in the current frame |

## Verification
An all-background frame shows that zero labels and silence on the merge port are kept apart from fresh allocation. A hand-drawn frame places foreground at the right end of one row and the left end of the next, so a missing edge mask turns up as a borrowed label rather than a fresh one. The same frame contains a U shape whose arms meet, which separates a correct merge pair from a plain minimum choice. A frame of isolated dots uses up a deliberately narrow label space to expose the overflow point and its clearing on the next frame. Seeded random frames at several densities, with idle gaps placed at random, compare every output against a two-dimensional reference labelling kept in the bench.

// File: rtl/ccl_pkg.sv
package ccl_pkg;
  // Which neighbours of the current pixel lie inside the image.
  // Bit order is used as an index into the neighbour label vector.
  typedef struct packed {
    logic ur;  // bit 3: upper-right
    logic up;  // bit 2: upper
    logic ul;  // bit 1: upper-left
    logic lf;  // bit 0: left
  } nbr_mask_t;

  localparam int NBR_CNT = 4;
  localparam int NB_LF = 0;
  localparam int NB_UL = 1;
  localparam int NB_UP = 2;
  localparam int NB_UR = 3;
endpackage

// File: rtl/ccl_row_delay.sv
// One row of labels: left register, a circular buffer of IMG_W-2 entries
// with a registered read port, then the upper and upper-left registers.
module ccl_row_delay #(
  parameter int IMG_W = 640,
  parameter int LBL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [LBL_W-1:0] new_lbl,
  output logic [LBL_W-1:0] lf_lbl,
  output logic [LBL_W-1:0] ul_lbl,
  output logic [LBL_W-1:0] up_lbl,
  output logic [LBL_W-1:0] ur_lbl
);
  localparam int DEPTH = IMG_W - 2;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [LBL_W-1:0] mem [DEPTH];
  logic [AW-1:0]    ptr_q;
  logic [AW-1:0]    ptr_inc;
  logic [AW-1:0]    rd_addr;
  logic [LBL_W-1:0] rd_q;
  logic [LBL_W-1:0] lf_q;
  logic [LBL_W-1:0] up_q;
  logic [LBL_W-1:0] ul_q;

  always_comb begin
    ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    // Read ahead: the entry needed by the next pixel is fetched now, so the
    // read port is registered. DEPTH >= 2 keeps it off the written entry.
    rd_addr = adv ? ptr_inc : ptr_q;
  end

  always_ff @(posedge clk) begin
    if (adv) mem[ptr_q] <= lf_q;
    rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      lf_q  <= '0;
      up_q  <= '0;
      ul_q  <= '0;
    end else if (adv) begin
      ptr_q <= ptr_inc;
      lf_q  <= new_lbl;
      up_q  <= rd_q;
      ul_q  <= up_q;
    end
  end

  assign lf_lbl = lf_q;
  assign ur_lbl = rd_q;
  assign up_lbl = up_q;
  assign ul_lbl = ul_q;
endmodule

// File: rtl/ccl_pos_track.sv
// Tracks line start and first row to mask neighbours outside the image.
module ccl_pos_track
  import ccl_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      adv,
  input  logic      sof,
  input  logic      eol,
  output nbr_mask_t msk
);
  logic line_start_q;
  logic first_row_q;
  logic ls;
  logic fr;

  always_comb begin
    ls     = sof | line_start_q;
    fr     = sof | first_row_q;
    msk.lf = ~ls;
    msk.ul = ~ls & ~fr;
    msk.up = ~fr;
    msk.ur = ~fr & ~eol;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_start_q <= 1'b1;
      first_row_q  <= 1'b1;
    end else if (adv) begin
      line_start_q <= eol;
      first_row_q  <= fr & ~eol;
    end
  end
endmodule

// File: rtl/ccl_label_alloc.sv
// Fresh label counter, restarted by start of frame, saturating at all-ones.
module ccl_label_alloc #(
  parameter int LBL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             sof,
  input  logic             req,
  output logic [LBL_W-1:0] give,
  output logic             exh_now
);
  localparam logic [LBL_W-1:0] MAXL = {LBL_W{1'b1}};
  localparam logic [LBL_W-1:0] ONE  = LBL_W'(1);

  logic [LBL_W-1:0] nxt_q;
  logic             exh_q;
  logic [LBL_W-1:0] base;

  always_comb begin
    base    = sof ? ONE : nxt_q;
    exh_now = sof ? 1'b0 : exh_q;
    give    = exh_now ? MAXL : base;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nxt_q <= ONE;
      exh_q <= 1'b0;
    end else if (adv) begin
      nxt_q <= base;
      exh_q <= exh_now;
      if (req && !exh_now) begin
        if (base == MAXL) exh_q <= 1'b1;
        else              nxt_q <= base + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ccl_nbr_resolve.sv
// Masks the four neighbours and picks label and merge pair.
module ccl_nbr_resolve
  import ccl_pkg::*;
#(
  parameter int LBL_W = 10
) (
  input  logic [NBR_CNT-1:0][LBL_W-1:0] nb,
  input  nbr_mask_t                     msk,
  output logic [LBL_W-1:0]              min_lbl,
  output logic                          any_nb,
  output logic                          merge,
  output logic [LBL_W-1:0]              pair_lo,
  output logic [LBL_W-1:0]              pair_hi
);
  function automatic logic [LBL_W-1:0] min_nz(input logic [LBL_W-1:0] a,
                                              input logic [LBL_W-1:0] b);
    if (a == '0)     return b;
    else if (b == '0) return a;
    else             return (a < b) ? a : b;
  endfunction

  logic [NBR_CNT-1:0]            mbits;
  logic [NBR_CNT-1:0][LBL_W-1:0] nm;
  logic [LBL_W-1:0]              g_side;
  logic [LBL_W-1:0]              u_side;

  assign mbits = msk;

  for (genvar i = 0; i < NBR_CNT; i++) begin : g_mask
    assign nm[i] = mbits[i] ? nb[i] : '0;
  end

  always_comb begin
    g_side  = min_nz(min_nz(nm[NB_UL], nm[NB_UP]), nm[NB_LF]);
    u_side  = nm[NB_UR];
    min_lbl = min_nz(g_side, u_side);
    any_nb  = (min_lbl != '0);
    merge   = (g_side != '0) && (u_side != '0) && (g_side != u_side);
    pair_lo = min_lbl;
    pair_hi = (g_side > u_side) ? g_side : u_side;
  end
endmodule

// File: rtl/ccl_stream_labeler.sv
module ccl_stream_labeler
  import ccl_pkg::*;
#(
  parameter int IMG_W = 640,
  parameter int LBL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_vld,
  input  logic             pix_fg,
  input  logic             pix_sof,
  input  logic             pix_eol,
  output logic             lbl_vld,
  output logic [LBL_W-1:0] lbl_out,
  output logic             mrg_vld,
  output logic [LBL_W-1:0] mrg_a,
  output logic [LBL_W-1:0] mrg_b,
  output logic             lbl_ovf
);
  initial begin
    if (IMG_W < 4) $error("IMG_W must be at least 4");
  end

  logic [NBR_CNT-1:0][LBL_W-1:0] nb;
  nbr_mask_t        msk;
  logic [LBL_W-1:0] min_lbl;
  logic             any_nb;
  logic             merge;
  logic [LBL_W-1:0] pair_lo;
  logic [LBL_W-1:0] pair_hi;
  logic [LBL_W-1:0] fresh;
  logic             exh_now;
  logic             req;
  logic [LBL_W-1:0] new_lbl;

  ccl_row_delay #(.IMG_W(IMG_W), .LBL_W(LBL_W)) u_delay (
    .clk    (clk),
    .rst    (rst),
    .adv    (pix_vld),
    .new_lbl(new_lbl),
    .lf_lbl (nb[NB_LF]),
    .ul_lbl (nb[NB_UL]),
    .up_lbl (nb[NB_UP]),
    .ur_lbl (nb[NB_UR])
  );

  ccl_pos_track u_pos (
    .clk(clk),
    .rst(rst),
    .adv(pix_vld),
    .sof(pix_sof),
    .eol(pix_eol),
    .msk(msk)
  );

  ccl_nbr_resolve #(.LBL_W(LBL_W)) u_res (
    .nb     (nb),
    .msk    (msk),
    .min_lbl(min_lbl),
    .any_nb (any_nb),
    .merge  (merge),
    .pair_lo(pair_lo),
    .pair_hi(pair_hi)
  );

  ccl_label_alloc #(.LBL_W(LBL_W)) u_alloc (
    .clk    (clk),
    .rst    (rst),
    .adv    (pix_vld),
    .sof    (pix_sof),
    .req    (req),
    .give   (fresh),
    .exh_now(exh_now)
  );

  always_comb begin
    req = pix_vld & pix_fg & ~any_nb;
    if (!pix_fg)     new_lbl = '0;
    else if (any_nb) new_lbl = min_lbl;
    else             new_lbl = fresh;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lbl_vld <= 1'b0;
      lbl_out <= '0;
      mrg_vld <= 1'b0;
      mrg_a   <= '0;
      mrg_b   <= '0;
      lbl_ovf <= 1'b0;
    end else begin
      lbl_vld <= pix_vld;
      mrg_vld <= pix_vld & pix_fg & merge;
      if (pix_vld) begin
        lbl_out <= new_lbl;
        lbl_ovf <= (lbl_ovf & ~pix_sof) | (req & exh_now);
        if (pix_fg && merge) begin
          mrg_a <= pair_lo;
          mrg_b <= pair_hi;
        end
      end
    end
  end
endmodule

// File: rtl/ccl_labeler_chk.sv
module ccl_labeler_chk #(
  parameter int LBL_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             pix_vld,
  input logic             pix_fg,
  input logic             lbl_vld,
  input logic [LBL_W-1:0] lbl_out,
  input logic             mrg_vld,
  input logic [LBL_W-1:0] mrg_a,
  input logic [LBL_W-1:0] mrg_b,
  input logic             lbl_ovf
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (lbl_vld == $past(pix_vld)));  // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(pix_vld)) |-> ($stable(lbl_out) && $stable(lbl_ovf) && !mrg_vld));  // R6

  AST_BG_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pix_vld) && !$past(pix_fg)) |-> (lbl_out == '0 && !mrg_vld));  // R1

  AST_FG_LABELLED: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pix_vld) && $past(pix_fg)) |-> (lbl_out != '0));  // R2

  AST_MERGE_ORDER: assert property (@(posedge clk) disable iff (rst)
    mrg_vld |-> (lbl_vld && mrg_a != '0 && mrg_a < mrg_b && lbl_out == mrg_a));  // R4

  AST_OVF_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(lbl_ovf) |-> (lbl_vld && (&lbl_out)));  // R7
endmodule

bind ccl_stream_labeler ccl_labeler_chk #(.LBL_W(LBL_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .pix_vld(pix_vld),
  .pix_fg (pix_fg),
  .lbl_vld(lbl_vld),
  .lbl_out(lbl_out),
  .mrg_vld(mrg_vld),
  .mrg_a  (mrg_a),
  .mrg_b  (mrg_b),
  .lbl_ovf(lbl_ovf)
);

// File: tb/ccl_stream_labeler_test.sv
module ccl_stream_labeler_test;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 8;
  localparam int LW   = 4;
  localparam int MAXL = (1 << LW) - 1;
  localparam int MAXR = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pix_vld = 1'b0;
  logic          pix_fg = 1'b0;
  logic          pix_sof = 1'b0;
  logic          pix_eol = 1'b0;
  logic          lbl_vld;
  logic [LW-1:0] lbl_out;
  logic          mrg_vld;
  logic [LW-1:0] mrg_a;
  logic [LW-1:0] mrg_b;
  logic          lbl_ovf;

  int n_tests = 0;
  int n_fail  = 0;

  bit pat [MAXR][W];
  int lab [MAXR][W];
  int m_nxt = 1;
  bit m_exh = 1'b0;
  bit m_ovf = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ccl_stream_labeler #(.IMG_W(W), .LBL_W(LW)) uut (
    .clk(clk), .rst(rst), .pix_vld(pix_vld), .pix_fg(pix_fg),
    .pix_sof(pix_sof), .pix_eol(pix_eol), .lbl_vld(lbl_vld),
    .lbl_out(lbl_out), .mrg_vld(mrg_vld), .mrg_a(mrg_a), .mrg_b(mrg_b),
    .lbl_ovf(lbl_ovf)
  );

  function automatic int min_nz(int a, int b);
    if (a == 0) return b;
    if (b == 0) return a;
    return (a < b) ? a : b;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Drive one cycle from a negedge and return at the next negedge.
  task automatic drive(bit v, bit f, bit s, bit e);
    pix_vld = v; pix_fg = f; pix_sof = s; pix_eol = e;
    @(negedge clk);
    pix_vld = 1'b0; pix_fg = 1'b0; pix_sof = 1'b0; pix_eol = 1'b0;
  endtask

  task automatic idle_check();
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    check(!lbl_vld && !mrg_vld, "R6", "idle cycle strobes", {lbl_vld, mrg_vld}, 0);
  endtask

  task automatic run_frame(int rows, bit bubbles);
    for (int r = 0; r < rows; r++) begin
      for (int c = 0; c < W; c++) begin
        int ul, up, ur, lf, g, e_lbl, e_a, e_b;
        bit e_mrg, fg, fresh_req;
        string req;
        if (bubbles && ($urandom % 6 == 0)) idle_check();
        fg = pat[r][c];
        if (r == 0 && c == 0) begin m_nxt = 1; m_exh = 1'b0; m_ovf = 1'b0; end
        ul = (r > 0 && c > 0) ? lab[r-1][c-1] : 0;
        up = (r > 0) ? lab[r-1][c] : 0;
        ur = (r > 0 && c < W - 1) ? lab[r-1][c+1] : 0;
        lf = (c > 0) ? lab[r][c-1] : 0;
        g = min_nz(min_nz(ul, up), lf);
        e_mrg = 1'b0; e_a = 0; e_b = 0; fresh_req = 1'b0;
        if (!fg) e_lbl = 0;
        else if (min_nz(g, ur) != 0) begin
          e_lbl = min_nz(g, ur);
          if (g != 0 && ur != 0 && g != ur) begin
            e_mrg = 1'b1; e_a = e_lbl; e_b = (g > ur) ? g : ur;
          end
        end else begin
          fresh_req = 1'b1;
          if (m_exh) begin e_lbl = MAXL; m_ovf = 1'b1; end
          else begin
            e_lbl = m_nxt;
            if (m_nxt == MAXL) m_exh = 1'b1; else m_nxt++;
          end
        end
        lab[r][c] = e_lbl;
        if (!fg) req = "R1";
        else if (fresh_req) req = (e_lbl == MAXL) ? "R7" : "R2";
        else if (e_mrg) req = "R4";
        else req = "R3";
        if (fg && (r == 0 || c == 0 || c == W - 1)) req = {req, "/R5"};
        drive(1'b1, fg, (r == 0 && c == 0), (c == W - 1));
        n_tests++;
        if (!lbl_vld || int'(lbl_out) != e_lbl || mrg_vld != e_mrg || lbl_ovf != m_ovf ||
            (e_mrg && (int'(mrg_a) != e_a || int'(mrg_b) != e_b))) begin
          n_fail++;
          $display("FAIL %s r%0d c%0d actual: vld=%0d lbl=%0d mrg=%0d a=%0d b=%0d ovf=%0d expected: vld=1 lbl=%0d mrg=%0d a=%0d b=%0d ovf=%0d",
                   req, r, c, lbl_vld, lbl_out, mrg_vld, mrg_a, mrg_b, lbl_ovf,
                   e_lbl, e_mrg, e_a, e_b, m_ovf);
        end
      end
    end
  endtask

  task automatic set_row(int r, logic [W-1:0] bits);
    for (int c = 0; c < W; c++) pat[r][c] = bits[W-1-c];
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8: reset values
    check(!lbl_vld && !mrg_vld && lbl_out == '0 && mrg_a == '0 && mrg_b == '0 && !lbl_ovf,
          "R8", "outputs after reset", {lbl_vld, mrg_vld, lbl_ovf, lbl_out}, 0);

    // R1: all-background frame
    for (int r = 0; r < 3; r++) set_row(r, '0);
    run_frame(3, 1'b0);
    idle_check();

    // R5 edges and R4 merge: directed shape
    set_row(0, 8'b00100001);
    set_row(1, 8'b10010010);
    set_row(2, 8'b00001100);
    set_row(3, 8'b10000000);
    set_row(4, 8'b10000001);
    run_frame(5, 1'b0);
    check(lab[1][0] == 3, "R5", "model row-start label", lab[1][0], 3);
    idle_check();

    // R7: isolated dots exhaust a 4-bit label space
    for (int r = 0; r < 8; r++) set_row(r, (r % 2 == 0) ? 8'b10101010 : 8'b00000000);
    run_frame(8, 1'b0);
    idle_check();
    check(lbl_ovf == 1'b1, "R7", "overflow held over idle", lbl_ovf, 1);

    // R7 clear, R6 bubbles, R2/R3/R4 random frames
    for (int f = 0; f < 8; f++) begin
      int rows, dens;
      rows = 4 + int'($urandom % 9);
      dens = (f % 3 == 0) ? 20 : ((f % 3 == 1) ? 45 : 70);
      for (int r = 0; r < rows; r++)
        for (int c = 0; c < W; c++) pat[r][c] = (int'($urandom % 100) < dens);
      run_frame(rows, 1'b1);
      idle_check();
    end

    // R2: single pixel frame after overflow restarts numbering
    set_row(0, 8'b01000000);
    set_row(1, 8'b00000000);
    run_frame(2, 1'b0);
    check(lab[0][1] == 1, "R2", "restart at 1", lab[0][1], 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule